// File: doc/BRIEF.md
# Table-Driven Multi-Way Branch Unit

This unit carries out a switch construct that takes two instructions over program memory. The first instruction, the prepare step, reads three operand bytes. The first byte is an entry count, which the unit keeps. The other two bytes are pushed onto a stack in internal RAM. That stack grows toward lower addresses.

The second instruction, the select step, scans a table that sits inline in program memory. Each entry is three bytes: one key byte, then a 16-bit destination with the upper byte first. The first key that equals the accumulator supplies the new program counter. If no key among the counted entries matches, the two bytes placed straight after the table are used instead.

The unit reads one program-memory byte per cycle. An instruction decoder starts each step with a one-cycle request and gives the address of the first operand or table byte. Fetching other instructions is left to the surrounding core.

Top module: `table_branch_unit`

## Requirements
- R1: After reset the stack pointer reads 0x5B, and `busy`, `pc_valid`, `stk_we` and `pc_out` are all zero.
- R2: A prepare request reads the bytes at `op_addr`, `op_addr+1` and `op_addr+2` in three consecutive cycles. The first of these bytes becomes the stored entry count. `busy` falls after exactly three clock edges.
- R3: The prepare step writes the second operand byte to stack address SP-1. In the next cycle it writes the third operand byte to SP-2.
- R4: When the prepare step completes, the stack pointer is lowered by 2, modulo 128. Successive prepare steps keep stacking downward.
- R5: A select request latches the accumulator at the request edge. Entry k occupies `op_addr+3k` (key), `+3k+1` (upper destination byte) and `+3k+2` (lower destination byte). The first entry in address order whose key equals the latched accumulator wins, and `pc_out` becomes {upper, lower}.
- R6: An entry whose key does not match is skipped whole, including its two destination bytes. If none of the counted entries matches, the default destination is read from `op_addr+3*count` (upper byte) and `op_addr+3*count+1` (lower byte).
- R7: With a stored count of zero, the select step takes the default destination directly from `op_addr` and `op_addr+1`.
- R8: `pc_valid` is a one-cycle pulse. It rises at the same edge at which `pc_out` takes the new destination. For a match at entry j it comes j+3 edges after the request edge. For the default it comes count+2 edges after the request edge.
- R9: A request of either kind that arrives while `busy` is high is ignored. If both requests arrive together while the unit is idle, the prepare step runs and the select request is dropped.
- R10: The stored count stays in force for any number of select steps, until the next prepare step replaces it.
- R11: During a scan the read address advances by 3 after each mismatching key, and by 1 between the bytes of a destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_go | input | 1 | Request a prepare step (count plus two stack bytes) |
| disp_go | input | 1 | Request a select step (table scan) |
| op_addr | input | 16 | Address of the first operand or table byte |
| acc | input | 8 | Accumulator value, sampled at a select request |
| pm_addr | output | 16 | Program-memory read address |
| pm_data | input | 8 | Program-memory read data (same-cycle read) |
| stk_we | output | 1 | Stack RAM write enable |
| stk_addr | output | 7 | Stack RAM write address |
| stk_wdata | output | 8 | Stack RAM write data |
| stk_ptr | output | 7 | Current stack pointer |
| busy | output | 1 | A step is in progress |
| pc_valid | output | 1 | One-cycle pulse: `pc_out` holds a new destination |
| pc_out | output | 16 | Selected program-counter value |

## Verification
The assertions check the following on every cycle:
- the prepare and select engines are never active at once;
- stack writes happen only during a prepare step, and the second write lands one address below the first;
- the stack pointer steps down by two;
- the read address follows the +1 and +3 strides;
- `pc_valid` is a single-cycle pulse that follows the final destination read.

Which entry wins, the value of the default destination, the effect of a zero count, how long the count persists and how requests during `busy` are rejected can only be shown by the bench's table scenarios. Those scenarios include duplicate keys, a changed accumulator after the request, and randomly generated tables compared against a reference scan.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
  localparam int ADDR_W      = 16;
  localparam int DATA_W      = 8;
  localparam int SP_W        = 7;
  localparam int ENTRY_BYTES = 3;
  localparam logic [SP_W-1:0] SP_RESET = 7'h5B;

  typedef enum logic [1:0] {SU_IDLE, SU_CNT, SU_HI, SU_LO} setup_st_e;
  typedef enum logic [1:0] {SC_IDLE, SC_CMP, SC_HI, SC_LO} scan_st_e;

  // address of the key byte of the following entry
  function automatic logic [ADDR_W-1:0] skip_entry(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(ENTRY_BYTES);
  endfunction

  // destination assembled from upper and lower bytes
  function automatic logic [ADDR_W-1:0] join_dest(input logic [DATA_W-1:0] hi,
                                                  input logic [DATA_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/tbu_stack_port.sv
module tbu_stack_port
  import tbu_pkg::*;
#(
  parameter int SPW = SP_W,
  parameter int DW  = DATA_W,
  parameter logic [SPW-1:0] SP_INIT = SP_RESET
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic           wr_second,
  input  logic [DW-1:0]  wr_byte,
  input  logic           drop2,
  output logic           stk_we,
  output logic [SPW-1:0] stk_addr,
  output logic [DW-1:0]  stk_wdata,
  output logic [SPW-1:0] sp
);
  logic [SPW-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sp_q <= SP_INIT;
    else if (drop2) sp_q <= sp_q - SPW'(2);
  end

  assign sp        = sp_q;
  assign stk_we    = wr_req;
  assign stk_addr  = wr_second ? (sp_q - SPW'(2)) : (sp_q - SPW'(1));
  assign stk_wdata = wr_byte;

  a_r4_sp_drops_two: assert property (@(posedge clk) disable iff (!rst_n)
    drop2 |=> sp == $past(sp) - SPW'(2));

  a_r3_second_below_first: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && wr_second && $past(stk_we)) |-> stk_addr == $past(stk_addr) - SPW'(1));
endmodule

// File: rtl/tbu_setup_seq.sv
module tbu_setup_seq
  import tbu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] pm_data,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] count,
  output logic          wr_req,
  output logic          wr_second,
  output logic [DW-1:0] wr_byte,
  output logic          drop2
);
  setup_st_e     st;
  logic [AW-1:0] ptr;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SU_IDLE;
      ptr   <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st)
        SU_IDLE: if (start) begin
          st  <= SU_CNT;
          ptr <= op_addr;
        end
        SU_CNT: begin
          cnt_q <= pm_data;
          ptr   <= ptr + AW'(1);
          st    <= SU_HI;
        end
        SU_HI: begin
          ptr <= ptr + AW'(1);
          st  <= SU_LO;
        end
        SU_LO: st <= SU_IDLE;
      endcase
    end
  end

  assign busy      = (st != SU_IDLE);
  assign rd_addr   = ptr;
  assign count     = cnt_q;
  assign wr_req    = (st == SU_HI) || (st == SU_LO);
  assign wr_second = (st == SU_LO);
  assign wr_byte   = pm_data;
  assign drop2     = (st == SU_LO);

  a_r2_reads_consecutive: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SU_HI || st == SU_LO) |-> rd_addr == $past(rd_addr) + AW'(1));
endmodule

// File: rtl/tbu_scan.sv
module tbu_scan
  import tbu_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] pm_data,
  output logic          busy,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] pc_out,
  output logic          pc_valid
);
  scan_st_e      st;
  logic [AW-1:0] ptr;
  logic [DW-1:0] key_q;
  logic [DW-1:0] left;
  logic [DW-1:0] hi_q;
  logic [AW-1:0] pc_q;
  logic          vld_q;

  // named scan events
  logic at_default, key_hit, key_miss;
  assign at_default = (st == SC_CMP) && (left == '0);
  assign key_hit    = (st == SC_CMP) && !at_default && (pm_data == key_q);
  assign key_miss   = (st == SC_CMP) && !at_default && (pm_data != key_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SC_IDLE;
      ptr   <= '0;
      key_q <= '0;
      left  <= '0;
      hi_q  <= '0;
      pc_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      unique case (st)
        SC_IDLE: if (start) begin
          st    <= SC_CMP;
          ptr   <= op_addr;
          key_q <= acc;
          left  <= count;
        end
        SC_CMP: begin
          if (at_default) begin
            hi_q <= pm_data;
            ptr  <= ptr + AW'(1);
            st   <= SC_LO;
          end else if (key_hit) begin
            ptr <= ptr + AW'(1);
            st  <= SC_HI;
          end else begin
            ptr  <= skip_entry(ptr);
            left <= left - DW'(1);
          end
        end
        SC_HI: begin
          hi_q <= pm_data;
          ptr  <= ptr + AW'(1);
          st   <= SC_LO;
        end
        SC_LO: begin
          pc_q  <= join_dest(hi_q, pm_data);
          vld_q <= 1'b1;
          st    <= SC_IDLE;
        end
      endcase
    end
  end

  assign busy     = (st != SC_IDLE);
  assign rd_addr  = ptr;
  assign pc_out   = pc_q;
  assign pc_valid = vld_q;

  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |=> !pc_valid);

  a_r8_valid_after_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> $past(st) == SC_LO);

  a_r11_miss_stride: assert property (@(posedge clk) disable iff (!rst_n)
    key_miss |=> rd_addr == $past(rd_addr) + AW'(ENTRY_BYTES));

  a_r11_dest_stride: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SC_HI || st == SC_LO) |-> rd_addr == $past(rd_addr) + AW'(1));

  a_r7_default_goes_low: assert property (@(posedge clk) disable iff (!rst_n)
    at_default |=> st == SC_LO);
endmodule

// File: rtl/table_branch_unit.sv
module table_branch_unit
  import tbu_pkg::*;
#(
  parameter int AW  = ADDR_W,
  parameter int DW  = DATA_W,
  parameter int SPW = SP_W,
  parameter logic [SPW-1:0] SP_INIT = SP_RESET
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           setup_go,
  input  logic           disp_go,
  input  logic [AW-1:0]  op_addr,
  input  logic [DW-1:0]  acc,
  output logic [AW-1:0]  pm_addr,
  input  logic [DW-1:0]  pm_data,
  output logic           stk_we,
  output logic [SPW-1:0] stk_addr,
  output logic [DW-1:0]  stk_wdata,
  output logic [SPW-1:0] stk_ptr,
  output logic           busy,
  output logic           pc_valid,
  output logic [AW-1:0]  pc_out
);
  logic          su_busy, sc_busy;
  logic [AW-1:0] su_addr, sc_addr;
  logic [DW-1:0] count;
  logic          wr_req, wr_second, drop2;
  logic [DW-1:0] wr_byte;
  logic          su_start, sc_start;

  assign busy     = su_busy || sc_busy;
  assign su_start = setup_go && !busy;
  assign sc_start = disp_go && !setup_go && !busy;
  assign pm_addr  = su_busy ? su_addr : sc_addr;

  tbu_setup_seq #(.AW(AW), .DW(DW)) u_setup (
    .clk(clk), .rst_n(rst_n), .start(su_start), .op_addr(op_addr),
    .pm_data(pm_data), .busy(su_busy), .rd_addr(su_addr), .count(count),
    .wr_req(wr_req), .wr_second(wr_second), .wr_byte(wr_byte), .drop2(drop2)
  );

  tbu_stack_port #(.SPW(SPW), .DW(DW), .SP_INIT(SP_INIT)) u_stack (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_second(wr_second),
    .wr_byte(wr_byte), .drop2(drop2), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .sp(stk_ptr)
  );

  tbu_scan #(.AW(AW), .DW(DW)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(sc_start), .op_addr(op_addr), .acc(acc),
    .count(count), .pm_data(pm_data), .busy(sc_busy), .rd_addr(sc_addr),
    .pc_out(pc_out), .pc_valid(pc_valid)
  );

  a_r9_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !(su_busy && sc_busy));

  a_r3_writes_only_in_prepare: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> su_busy);

  a_r9_busy_blocks_scan: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_busy && disp_go) |=> !$rose(su_busy));
endmodule

// File: tb/table_branch_unit_tb.sv
module table_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup_go = 1'b0, disp_go = 1'b0;
  logic [15:0] op_addr = '0;
  logic [7:0]  acc = '0;
  logic [15:0] pm_addr;
  logic [7:0]  pm_data;
  logic        stk_we;
  logic [6:0]  stk_addr, stk_ptr;
  logic [7:0]  stk_wdata;
  logic        busy, pc_valid;
  logic [15:0] pc_out;

  logic [7:0] mem  [0:1023];
  logic [7:0] stkm [0:127];
  int checks = 0, errors = 0;
  logic [6:0] exp_sp;
  logic [7:0] cur_cnt;

  always #2.5 clk = ~clk;

  assign pm_data = mem[pm_addr[9:0]];
  always @(posedge clk) if (stk_we) stkm[stk_addr] <= stk_wdata;

  table_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .setup_go(setup_go), .disp_go(disp_go),
    .op_addr(op_addr), .acc(acc), .pm_addr(pm_addr), .pm_data(pm_data),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .stk_ptr(stk_ptr), .busy(busy), .pc_valid(pc_valid), .pc_out(pc_out)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference scan: first matching key in address order, else default after table
  function automatic logic [15:0] ref_dest(input int base, input int cnt,
                                           input logic [7:0] key, output int lat);
    for (int k = 0; k < cnt; k++) begin
      if (mem[(base + 3*k) & 1023] == key) begin
        lat = k + 3;
        return {mem[(base + 3*k + 1) & 1023], mem[(base + 3*k + 2) & 1023]};
      end
    end
    lat = cnt + 2;
    return {mem[(base + 3*cnt) & 1023], mem[(base + 3*cnt + 1) & 1023]};
  endfunction

  task automatic do_setup(input int base, input logic [7:0] c,
                          input logic [7:0] b1, input logic [7:0] b2);
    int n;
    logic [6:0] sp0;
    mem[base & 1023] = c;
    mem[(base + 1) & 1023] = b1;
    mem[(base + 2) & 1023] = b2;
    @(negedge clk);
    sp0 = exp_sp;
    op_addr = 16'(base);
    setup_go = 1'b1;
    @(posedge clk);
    #1 setup_go = 1'b0;
    n = 0;
    while (busy && n < 50) begin
      @(posedge clk);
      n++;
      #1;
    end
    chk("R2", "prepare edges", n, 3);
    chk("R3", "byte at SP-1", stkm[sp0 - 7'd1], b1);
    chk("R3", "byte at SP-2", stkm[sp0 - 7'd2], b2);
    exp_sp = sp0 - 7'd2;
    chk("R4", "stack pointer", stk_ptr, exp_sp);
    cur_cnt = c;
  endtask

  task automatic do_disp(input int base, input logic [7:0] key, input bit poke,
                         input string req);
    int n, lat;
    logic [15:0] exp;
    exp = ref_dest(base, int'(cur_cnt), key, lat);
    @(negedge clk);
    op_addr = 16'(base);
    acc = key;
    disp_go = 1'b1;
    @(posedge clk);
    #1 disp_go = 1'b0;
    acc = ~key;  // R5: the sampled key must be the one at the request edge
    n = 0;
    while (n < 400) begin
      @(negedge clk);
      setup_go = poke && (n == 1);
      disp_go  = poke && (n == 1);
      @(posedge clk);
      n++;
      #1;
      if (pc_valid) break;
    end
    setup_go = 1'b0;
    disp_go = 1'b0;
    chk(req, "destination", pc_out, exp);
    chk("R8 R11", "edges to pc_valid", n, lat);
    @(posedge clk);
    #1 chk("R8", "pulse width", pc_valid, 0);
    if (poke) chk("R9", "stack pointer after ignored requests", stk_ptr, exp_sp);
  endtask

  task automatic put_entry(input int base, input int k, input logic [7:0] key,
                           input logic [15:0] d);
    mem[(base + 3*k) & 1023] = key;
    mem[(base + 3*k + 1) & 1023] = d[15:8];
    mem[(base + 3*k + 2) & 1023] = d[7:0];
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1BAD5EED));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 128; i++) stkm[i] = 8'h00;
    exp_sp = 7'h5B;
    cur_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset SP", stk_ptr, 7'h5B);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset pc_valid", pc_valid, 0);
    chk("R1", "reset pc_out", pc_out, 0);
    chk("R1", "reset stk_we", stk_we, 0);

    do_setup(100, 8'd3, 8'hAA, 8'h55);
    put_entry(200, 0, 8'h11, 16'h1234);
    put_entry(200, 1, 8'h22, 16'h5678);
    put_entry(200, 2, 8'h33, 16'h9ABC);
    mem[209] = 8'hDE; mem[210] = 8'hF0;
    do_disp(200, 8'h11, 0, "R5");
    do_disp(200, 8'h33, 0, "R5");
    do_disp(200, 8'h44, 0, "R6");  // default at 0xDEF0
    // duplicate keys: the earlier entry wins (R5)
    put_entry(220, 0, 8'h07, 16'hAAAA);
    put_entry(220, 1, 8'h22, 16'h0101);
    put_entry(220, 2, 8'h22, 16'h0202);
    do_disp(220, 8'h22, 0, "R5");
    // R10: count of 3 still applies to another table
    do_disp(220, 8'h99, 0, "R10");

    // R7: zero count takes the default directly
    do_setup(110, 8'd0, 8'h01, 8'h02);
    mem[300] = 8'hC3; mem[301] = 8'h3C;
    do_disp(300, 8'hC3, 0, "R7");
    // R9: requests during a scan are ignored
    do_disp(300, 8'h00, 1, "R9");

    // R9: both requests together: prepare runs, select is dropped
    mem[120] = 8'd2; mem[121] = 8'h5A; mem[122] = 8'hA5;
    @(negedge clk);
    op_addr = 16'd120;
    setup_go = 1'b1;
    disp_go = 1'b1;
    @(posedge clk);
    #1 setup_go = 1'b0;
    disp_go = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk);
      #1 if (pc_valid) chk("R9", "select dropped", 1, 0);
    end
    exp_sp = exp_sp - 7'd2;
    cur_cnt = 8'd2;
    chk("R9", "prepare ran", stk_ptr, exp_sp);
    chk("R3", "simultaneous byte at SP-1", stkm[exp_sp + 7'd1], 8'h5A);

    // random tables
    for (int it = 0; it < 60; it++) begin
      int base;
      logic [7:0] key;
      if (it % 4 == 0) do_setup(10 + 3 * (it % 20), 8'($urandom_range(0, 8)),
                                8'($urandom), 8'($urandom));
      base = 400 + int'($urandom_range(0, 500));
      for (int k = 0; k <= 9; k++)
        put_entry(base, k, 8'($urandom_range(0, 15)), 16'($urandom));
      key = (it % 3 == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
      do_disp(base, key, (it % 7 == 3), (it % 2 == 0) ? "R5" : "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule